// File: doc/BRIEF.md
# Memory Slave with Ready Countdown

This block sits between a single bus master and a small synchronous static RAM. The master places an address, a read or write strobe and write data on the bus for one cycle and may drop them at once. The slave registers the command into pin-side registers, which drive the RAM's chip select, write enable, address and data. A synchronous RAM model sits inside the same top level. Returning read data passes through one input register and then through a small hold stage, so the value stays on the output after it arrives.

Instead of a single acknowledge signal, the slave reports a 2-bit countdown: the number of cycles left before the read data of the most recent accepted command can be taken. Zero means the data is on the output now. The slave is built for one fixed pipeline level, set by a parameter. That level tells the master how early it may issue the next command, so the master can overlap a new command with one still in flight. A command that arrives earlier than the level allows is dropped, and a sticky error flag is raised.

Top module: `msl_slave`

## Requirements
- R1: While reset is high and in the first cycle after it, `rdy_cnt` is 0, `rd_data` is 0 and `proto_err` is 0.
- R2: An accepted command causes no output change in its own cycle. In the next cycle `rdy_cnt` reads 2. It then falls by one each cycle until it reaches 0 and stays at 0 until the next accepted command.
- R3: An accepted read of address A shows the RAM word at A on `rd_data` exactly three cycles after the command cycle, in the cycle where its countdown reaches 0. That word includes every write accepted before the read.
- R4: `rd_data` keeps the last delivered read word until the next read word arrives.
- R5: An accepted write stores its data in the RAM and never changes `rd_data`.
- R6: Whether a command is accepted depends on the current `rdy_cnt` and the level PIPE_LVL. At level 1 it needs `rdy_cnt`==0. At level 2 it needs `rdy_cnt`<=1. At level 3 it is always accepted. At level 0 it needs `rdy_cnt`==0, and the countdown must not have reached 0 in this same cycle, so the master waits one cycle after the data becomes valid. Commands that follow these rules never set `proto_err`.
- R7: A command that breaks the rule in R6 is ignored: it does not touch the RAM, the countdown or the read data. It sets `proto_err`, which then stays at 1 until reset.
- R8: A cycle with both `req_rd` and `req_wr` high is treated as a rejected command, as in R7.
- R9: At level 3, reads issued in consecutive cycles deliver their words on consecutive cycles, in command order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read strobe, valid for one cycle |
| req_wr | input | 1 | Write strobe, valid for one cycle |
| req_addr | input | ADDR_W | Word address of the command |
| req_wdata | input | DATA_W | Write data of the command |
| rdy_cnt | output | 2 | Cycles left until read data is valid (0 = valid now) |
| rd_data | output | DATA_W | Read data, held until the next read word arrives |
| proto_err | output | 1 | Sticky flag for rejected commands |

## Verification
The assertions assume that reset is held for at least two clock edges before it is released. This makes the first history-based comparisons see reset values. Beyond that they make no assumption about the strobes, because rejected and conflicting commands are part of the defined behaviour. Before reading any address, the stimulus writes every RAM word, so no read returns an uninitialised word. In the first phase, commands are issued only when the reference model says the declared level allows them. In the second phase, early commands and double strobes are injected on purpose.

// File: rtl/msl_pkg.sv
package msl_pkg;
  localparam int unsigned CNT_W   = 2;
  // pin register + RAM read register + input register, minus the visible cycle
  localparam int unsigned ACC_LAT = 2;
  typedef logic [CNT_W-1:0] rcnt_t;
endpackage

// File: rtl/msl_ctrl.sv
module msl_ctrl
  import msl_pkg::*;
#(
  parameter int unsigned PIPE_LVL = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  req_rd,
  input  logic  req_wr,
  output logic  accept,
  output rcnt_t cnt_q,
  output logic  err_q
);
  logic any_req;
  logic clash;
  logic slot_ok;
  logic reject;
  logic done_q;

  assign any_req = req_rd | req_wr;
  assign clash   = req_rd & req_wr;

  generate
    if (PIPE_LVL == 0) begin : g_lvl_idle
      assign slot_ok = (cnt_q == '0) && !done_q;
    end else begin : g_lvl_overlap
      assign slot_ok = (int'(cnt_q) < int'(PIPE_LVL));
    end
  endgenerate

  assign accept = any_req && slot_ok && !clash;
  assign reject = any_req && !accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= (cnt_q == rcnt_t'(1)) && !accept;
      if (accept)
        cnt_q <= rcnt_t'(ACC_LAT);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - rcnt_t'(1);
      if (reject)
        err_q <= 1'b1;
    end
  end

  assert_cnt_load_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> cnt_q == rcnt_t'(ACC_LAT));
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!accept && cnt_q != '0) |=> cnt_q == $past(cnt_q) - rcnt_t'(1));
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= int'(ACC_LAT));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  assert_clash_R8: assert property (@(posedge clk) disable iff (rst)
    clash |=> err_q);
endmodule

// File: rtl/msl_pin_stage.sv
module msl_pin_stage #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              pin_cs,
  output logic              pin_we,
  output logic [ADDR_W-1:0] pin_addr,
  output logic [DATA_W-1:0] pin_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_cs <= 1'b0;
      pin_we <= 1'b0;
    end else begin
      pin_cs <= accept;
      pin_we <= accept && req_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pin_addr  <= req_addr;
      pin_wdata <= req_wdata;
    end
  end

  assert_we_needs_cs_R5: assert property (@(posedge clk) disable iff (rst)
    pin_we |-> pin_cs);
endmodule

// File: rtl/msl_sram.sv
module msl_sram #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cs && we)
      mem[addr] <= wdata;
    if (cs && !we)
      rdata_q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid_q <= 1'b0;
    else     rvalid_q <= cs && !we;
  end
endmodule

// File: rtl/msl_ret.sv
module msl_ret #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              fresh_q,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q    <= '0;
      hold_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= in_valid;
      if (in_valid) rx_q   <= in_data;
      if (fresh_q)  hold_q <= rx_q;
    end
  end

  assign rd_data = fresh_q ? rx_q : hold_q;

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !fresh_q |-> rd_data == $past(rd_data));
endmodule

// File: rtl/msl_slave.sv
module msl_slave
  import msl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PIPE_LVL = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [CNT_W-1:0]  rdy_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic              proto_err
);
  logic              accept;
  rcnt_t             cnt_q;
  logic              pin_cs;
  logic              pin_we;
  logic [ADDR_W-1:0] pin_addr;
  logic [DATA_W-1:0] pin_wdata;
  logic [DATA_W-1:0] ram_q;
  logic              ram_v;
  logic              fresh;

  initial begin
    assert (PIPE_LVL <= 3) else $error("PIPE_LVL out of range");
  end

  msl_ctrl #(.PIPE_LVL(PIPE_LVL)) u_ctrl (
    .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
    .accept(accept), .cnt_q(cnt_q), .err_q(proto_err)
  );

  msl_pin_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pin (
    .clk(clk), .rst(rst), .accept(accept), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .pin_cs(pin_cs), .pin_we(pin_we), .pin_addr(pin_addr), .pin_wdata(pin_wdata)
  );

  msl_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst(rst), .cs(pin_cs), .we(pin_we), .addr(pin_addr),
    .wdata(pin_wdata), .rdata_q(ram_q), .rvalid_q(ram_v)
  );

  msl_ret #(.DATA_W(DATA_W)) u_ret (
    .clk(clk), .rst(rst), .in_valid(ram_v), .in_data(ram_q),
    .fresh_q(fresh), .rd_data(rd_data)
  );

  assign rdy_cnt = cnt_q;

  assert_reject_no_pin_R7: assert property (@(posedge clk) disable iff (rst)
    ((req_rd || req_wr) && !accept) |=> !pin_cs);
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(proto_err) |-> $past(req_rd || req_wr));
  assert_fresh_after_read_R3: assert property (@(posedge clk) disable iff (rst)
    fresh |-> $past(ram_v));
  assert_write_keeps_data_R5: assert property (@(posedge clk) disable iff (rst)
    (pin_cs && pin_we) |=> !ram_v);
endmodule

// File: tb/sim_msl_slave.sv
module sim_msl_slave;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NL = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rd   [NL];
  logic          wr   [NL];
  logic [AW-1:0] ad   [NL];
  logic [DW-1:0] wd   [NL];
  logic [1:0]    cnt_o[NL];
  logic [DW-1:0] rdo  [NL];
  logic          err_o[NL];

  msl_slave #(.ADDR_W(AW), .DATA_W(DW), .PIPE_LVL(0)) u0 (
    .clk(clk), .rst(rst), .req_rd(rd[0]), .req_wr(wr[0]), .req_addr(ad[0]),
    .req_wdata(wd[0]), .rdy_cnt(cnt_o[0]), .rd_data(rdo[0]), .proto_err(err_o[0]));
  msl_slave #(.ADDR_W(AW), .DATA_W(DW), .PIPE_LVL(1)) u1 (
    .clk(clk), .rst(rst), .req_rd(rd[1]), .req_wr(wr[1]), .req_addr(ad[1]),
    .req_wdata(wd[1]), .rdy_cnt(cnt_o[1]), .rd_data(rdo[1]), .proto_err(err_o[1]));
  msl_slave #(.ADDR_W(AW), .DATA_W(DW), .PIPE_LVL(2)) u2 (
    .clk(clk), .rst(rst), .req_rd(rd[2]), .req_wr(wr[2]), .req_addr(ad[2]),
    .req_wdata(wd[2]), .rdy_cnt(cnt_o[2]), .rd_data(rdo[2]), .proto_err(err_o[2]));
  msl_slave #(.ADDR_W(AW), .DATA_W(DW), .PIPE_LVL(3)) u3 (
    .clk(clk), .rst(rst), .req_rd(rd[3]), .req_wr(wr[3]), .req_addr(ad[3]),
    .req_wdata(wd[3]), .rdy_cnt(cnt_o[3]), .rd_data(rdo[3]), .proto_err(err_o[3]));

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [31:0] seed = 32'h1234_5679;

  int            m_cnt  [NL];
  bit            m_done [NL];
  bit            m_err  [NL];
  logic [DW-1:0] m_mem  [NL][DEPTH];
  bit            pv1 [NL];
  bit            pv2 [NL];
  logic [DW-1:0] pd1 [NL];
  logic [DW-1:0] pd2 [NL];
  logic [DW-1:0] m_rd [NL];
  bit            arr_now [NL];
  bit            arr_prev[NL];
  int            recent_wr[NL];
  bit            last_clash[NL];
  int            sweep[NL];
  int            phase;

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic bit ok_f(int l);
    if (l == 0) return (m_cnt[l] == 0) && !m_done[l];
    return m_cnt[l] < l;
  endfunction

  task automatic chk(string tag, int l, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s u%0d t=%0t: got %0h expected %0h", tag, l, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < NL; l++) begin
      m_cnt[l] = 0; m_done[l] = 0; m_err[l] = 0;
      pv1[l] = 0; pv2[l] = 0; pd1[l] = '0; pd2[l] = '0; m_rd[l] = '0;
      arr_now[l] = 0; arr_prev[l] = 0; recent_wr[l] = 0; last_clash[l] = 0;
      sweep[l] = 0;
    end
  endtask

  task automatic check_all();
    for (int l = 0; l < NL; l++) begin
      string dtag;
      string etag;
      chk("R2", l, 32'(cnt_o[l]), 32'(m_cnt[l]));
      etag = (phase == 1) ? "R6" : (last_clash[l] ? "R8" : "R7");
      chk(etag, l, 32'(err_o[l]), 32'(m_err[l]));
      if (arr_now[l]) dtag = (l == 3 && arr_prev[l]) ? "R9" : "R3";
      else            dtag = (recent_wr[l] > 0) ? "R5" : "R4";
      chk(dtag, l, 32'(rdo[l]), 32'(m_rd[l]));
    end
  endtask

  task automatic pick_inputs();
    for (int l = 0; l < NL; l++) begin
      logic [31:0] r;
      r = nxt();
      rd[l] = 1'b0; wr[l] = 1'b0;
      ad[l] = AW'(r[11:8]);
      wd[l] = DW'(r[23:16]);
      if (phase == 1) begin
        if (ok_f(l)) begin
          if (sweep[l] < DEPTH) begin
            wr[l] = 1'b1;
            ad[l] = AW'(sweep[l]);
            wd[l] = DW'(sweep[l] * 7 + l * 29 + 3);
            sweep[l]++;
          end else if (r[0] || l == 3) begin
            if (r[2:1] != 2'b00) rd[l] = 1'b1;
            else                 wr[l] = 1'b1;
          end
        end
      end else begin
        if (r[0]) begin
          if (r[3:1] == 3'b000) begin rd[l] = 1'b1; wr[l] = 1'b1; end
          else if (r[1])        rd[l] = 1'b1;
          else                  wr[l] = 1'b1;
        end
      end
    end
  endtask

  task automatic model_step();
    for (int l = 0; l < NL; l++) begin
      bit any, acc, rej;
      any = rd[l] || wr[l];
      acc = any && ok_f(l) && !(rd[l] && wr[l]);
      rej = any && !acc;
      arr_prev[l] = arr_now[l];
      arr_now[l]  = pv2[l];
      if (pv2[l]) m_rd[l] = pd2[l];
      pv2[l] = pv1[l]; pd2[l] = pd1[l];
      pv1[l] = acc && rd[l];
      pd1[l] = m_mem[l][ad[l]];
      if (acc && wr[l]) m_mem[l][ad[l]] = wd[l];
      if (acc && wr[l]) recent_wr[l] = 3;
      else if (recent_wr[l] > 0) recent_wr[l]--;
      m_done[l] = (m_cnt[l] == 1) && !acc;
      if (acc) m_cnt[l] = 2;
      else if (m_cnt[l] > 0) m_cnt[l]--;
      if (rej) begin m_err[l] = 1; last_clash[l] = rd[l] && wr[l]; end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin
      rd[l] = 0; wr[l] = 0; ad[l] = '0; wd[l] = '0;
    end
    phase = 1;
    model_reset();
    repeat (4) @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      chk("R1", l, 32'(cnt_o[l]), 0);
      chk("R1", l, 32'(rdo[l]), 0);
      chk("R1", l, 32'(err_o[l]), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      chk("R1", l, 32'(cnt_o[l]), 0);
      chk("R1", l, 32'(rdo[l]), 0);
      chk("R1", l, 32'(err_o[l]), 0);
    end
    // legal traffic at each declared level: write sweep then mixed commands
    for (int c = 0; c < 600; c++) begin
      check_all();
      pick_inputs();
      model_step();
      @(negedge clk);
    end
    // early commands and double strobes
    phase = 2;
    for (int c = 0; c < 600; c++) begin
      check_all();
      pick_inputs();
      model_step();
      @(negedge clk);
    end
    check_all();
    for (int l = 0; l < NL; l++) begin
      rd[l] = 0; wr[l] = 0;
    end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      chk("R1", l, 32'(err_o[l]), 0);
      chk("R1", l, 32'(cnt_o[l]), 0);
      chk("R1", l, 32'(rdo[l]), 0);
    end
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule